// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block keeps the two threshold offsets of a FIFO and turns the FIFO's current occupancy into an almost-empty flag and an almost-full flag. Almost-empty is raised when the stored word count has fallen to the empty threshold or below it. Almost-full is raised when the remaining free space has shrunk to the full threshold or below it. The FIFO memory itself lies outside this block. The block only receives the occupancy count.

At master reset, both thresholds take one of eight preset values. The load-strobe pin and a 2-bit preset select choose which one. The same reset also captures several configuration pins:

- the data-bus width, 18 or 9 bits;
- whether a parity bit is interspersed in the 18-bit word;
- the timing of each flag, either combinational or registered.

After reset, the thresholds can be rewritten in two ways. In parallel, a load strobe takes one word from the data bus. In serial, a slow shift clock with an enable and a data bit shifts the value in, and the block samples that shift clock with its own clock. Partial reset restarts both load sequences and keeps the thresholds.

No interface of this block carries a stream, so there is no valid/ready handshake and no back-pressure. Every load strobe is taken in the cycle it is sampled. Every sampled rising edge of the shift clock, with the enable high, is taken as one bit.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mrst_i` is high, both offsets load the preset with index k = {`ld_i`, `fsel_i`}. The preset value is min(2^(k+3)-1, DEPTH-1), for example 7, 15, 31 and so on up to 1023.
- R2: Parallel loading writes the empty offset on the first sampled `ld_i` strobe and the full offset on the second. The sequence then starts again with the empty offset.
- R3: In the 18-bit width without parity, the offset is taken from `d_i[15:0]`, including bit 8. Bits 17:16 and any bits above the offset width are discarded.
- R4: In the 18-bit width with parity, bit 8 is skipped. The offset is taken from {`d_i[17:9]`, `d_i[7:0]`}, truncated to the offset width.
- R5: In the 9-bit width, only `d_i[8:0]` is used, zero-extended, and the parity setting has no effect.
- R6: Serial loading works as follows.
  - The block counts a bit on each rising edge of `sclk_i` that it samples while `sen_i` is high, taking `sdi_i` at that edge.
  - Bits arrive LSB first: first the empty offset, then the full offset.
  - Both offsets update together once 2*OW bits have arrived.
- R7: `ae_o` is high exactly when `count_i` is at or below the empty offset.
- R8: `af_o` is high exactly when DEPTH - `count_i` is at or below the full offset.
- R9: The timing of each flag is captured at master reset.
  - Combinational timing: the flag follows `count_i` in the same cycle.
  - Registered timing: the flag shows the comparison from one clock earlier.
- R10: `prst_i` leaves both offsets unchanged and restarts both load sequences. The next parallel word then goes to the empty offset, and a partly shifted serial value is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| mrst_i | input | 1 | Synchronous master reset, active high; captures presets and configuration |
| prst_i | input | 1 | Synchronous partial reset, active high |
| fsel_i | input | 2 | Preset select, low two bits of the preset index |
| ld_i | input | 1 | Parallel load strobe; top bit of the preset index during master reset |
| wide_i | input | 1 | 1 = 18-bit data bus, 0 = 9-bit; captured at master reset |
| ip_i | input | 1 | 1 = parity bit interspersed at bit 8; captured at master reset |
| ae_async_i | input | 1 | 1 = combinational almost-empty timing; captured at master reset |
| af_async_i | input | 1 | 1 = combinational almost-full timing; captured at master reset |
| d_i | input | 18 | Parallel offset word |
| sclk_i | input | 1 | Serial shift clock, sampled by clk_i |
| sen_i | input | 1 | Serial enable |
| sdi_i | input | 1 | Serial data bit |
| count_i | input | CW | FIFO occupancy, 0 to DEPTH |
| ae_o | output | 1 | Almost-empty flag |
| af_o | output | 1 | Almost-full flag |

## Verification
The assertions check on every clock that each flag matches its comparison against the stored offset. They check it with the timing selected for that flag: in the same cycle for combinational timing, and from the previous cycle's values for registered timing. They also check that a partial reset never changes either offset.

Only the bench scenarios can show that the stored offset values themselves are correct. This covers:
- the eight presets;
- the alternation of parallel words;
- the bit selection for each bus width and parity setting;
- LSB-first serial assembly;
- the loss of a partial serial shift at partial reset.

// File: rtl/flo_pkg.sv
package flo_pkg;
  localparam int BUS_W = 18;
  localparam int ASM_W = 17;

  function automatic int preset_offset(input logic [2:0] idx, input int depth);
    int v;
    v = (1 << (int'(idx) + 3)) - 1;
    if (v > depth - 1) v = depth - 1;
    return v;
  endfunction

  function automatic logic [ASM_W-1:0] assemble_word(input logic [BUS_W-1:0] d,
                                                     input logic wide,
                                                     input logic ip);
    logic [ASM_W-1:0] r;
    if (!wide)   r = {8'd0, d[8:0]};
    else if (ip) r = {d[17:9], d[7:0]};
    else         r = {1'b0, d[15:0]};
    return r;
  endfunction
endpackage

// File: rtl/flo_ser.sv
module flo_ser #(
  parameter int OW = 10
) (
  input  logic          clk_i,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic          sclk_i,
  input  logic          sen_i,
  input  logic          sdi_i,
  output logic          commit_o,
  output logic [2*OW-1:0] word_o
);
  localparam int SW   = 2 * OW;
  localparam int CNTW = $clog2(SW) + 1;
  localparam logic [CNTW-1:0] LAST = CNTW'(SW - 1);

  logic s1, s2, sen_s, sdi_s;
  logic [SW-1:0] shreg;
  logic [CNTW-1:0] cnt;
  logic take;

  assign take     = s1 & ~s2 & sen_s;
  assign word_o   = {sdi_s, shreg[SW-1:1]};
  assign commit_o = take && (cnt == LAST) && !mrst_i && !prst_i;

  always_ff @(posedge clk_i) begin
    s1    <= sclk_i;
    s2    <= s1;
    sen_s <= sen_i;
    sdi_s <= sdi_i;
    if (mrst_i || prst_i) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (take) begin
      shreg <= word_o;
      cnt   <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flo_par.sv
module flo_par
  import flo_pkg::*;
#(
  parameter int OW = 10
) (
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic             ld_i,
  input  logic             wide_i,
  input  logic             ip_i,
  input  logic [BUS_W-1:0] d_i,
  output logic             wr_ae_o,
  output logic             wr_af_o,
  output logic [OW-1:0]    val_o
);
  logic             second;
  logic [ASM_W-1:0] asm_w;

  assign asm_w   = assemble_word(d_i, wide_i, ip_i);
  assign val_o   = asm_w[OW-1:0];
  assign wr_ae_o = ld_i && !second && !mrst_i && !prst_i;
  assign wr_af_o = ld_i &&  second && !mrst_i && !prst_i;

  always_ff @(posedge clk_i) begin
    if (mrst_i || prst_i) second <= 1'b0;
    else if (ld_i)        second <= ~second;
  end
endmodule

// File: rtl/flo_flag.sv
module flo_flag #(
  parameter int CW = 11,
  parameter int OW = 10
) (
  input  logic          clk_i,
  input  logic [CW-1:0] level_i,
  input  logic [OW-1:0] thr_i,
  input  logic          async_i,
  output logic          flag_o
);
  logic hit, hit_q;

  assign hit = (level_i <= CW'(thr_i));

  always_ff @(posedge clk_i) hit_q <= hit;

  assign flag_o = async_i ? hit : hit_q;
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import flo_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int OW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             mrst_i,
  input  logic             prst_i,
  input  logic [1:0]       fsel_i,
  input  logic             ld_i,
  input  logic             wide_i,
  input  logic             ip_i,
  input  logic             ae_async_i,
  input  logic             af_async_i,
  input  logic [BUS_W-1:0] d_i,
  input  logic             sclk_i,
  input  logic             sen_i,
  input  logic             sdi_i,
  input  logic [CW-1:0]    count_i,
  output logic             ae_o,
  output logic             af_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic wide_q, ip_q, ae_async_q, af_async_q;
  logic [OW-1:0] ae_off_q, af_off_q, preset, par_val;
  logic par_wr_ae, par_wr_af, ser_commit;
  logic [2*OW-1:0] ser_word;
  logic [CW-1:0] free_lvl;

  assign preset   = OW'(preset_offset({ld_i, fsel_i}, DEPTH));
  assign free_lvl = DEPTH_C - count_i;

  always_ff @(posedge clk_i) begin
    if (mrst_i) begin
      wide_q     <= wide_i;
      ip_q       <= ip_i;
      ae_async_q <= ae_async_i;
      af_async_q <= af_async_i;
    end
  end

  flo_par #(.OW(OW)) u_par (
    .clk_i(clk_i), .mrst_i(mrst_i), .prst_i(prst_i), .ld_i(ld_i),
    .wide_i(wide_q), .ip_i(ip_q), .d_i(d_i),
    .wr_ae_o(par_wr_ae), .wr_af_o(par_wr_af), .val_o(par_val)
  );

  flo_ser #(.OW(OW)) u_ser (
    .clk_i(clk_i), .mrst_i(mrst_i), .prst_i(prst_i), .sclk_i(sclk_i),
    .sen_i(sen_i), .sdi_i(sdi_i), .commit_o(ser_commit), .word_o(ser_word)
  );

  always_ff @(posedge clk_i) begin
    if (mrst_i) begin
      ae_off_q <= preset;
      af_off_q <= preset;
    end else if (!prst_i) begin
      if (ser_commit) begin
        ae_off_q <= ser_word[OW-1:0];
        af_off_q <= ser_word[2*OW-1:OW];
      end else begin
        if (par_wr_ae) ae_off_q <= par_val;
        if (par_wr_af) af_off_q <= par_val;
      end
    end
  end

  flo_flag #(.CW(CW), .OW(OW)) u_ae (
    .clk_i(clk_i), .level_i(count_i), .thr_i(ae_off_q),
    .async_i(ae_async_q), .flag_o(ae_o)
  );

  flo_flag #(.CW(CW), .OW(OW)) u_af (
    .clk_i(clk_i), .level_i(free_lvl), .thr_i(af_off_q),
    .async_i(af_async_q), .flag_o(af_o)
  );
endmodule

// File: rtl/flo_chk.sv
module flo_chk #(
  parameter int DEPTH = 1024,
  parameter int OW    = 10,
  parameter int CW    = 11
) (
  input logic          clk_i,
  input logic          mrst_i,
  input logic          prst_i,
  input logic [CW-1:0] count_i,
  input logic [OW-1:0] ae_off_q,
  input logic [OW-1:0] af_off_q,
  input logic          ae_async_q,
  input logic          af_async_q,
  input logic          ae_o,
  input logic          af_o
);
  logic [CW-1:0] free_c;
  assign free_c = CW'(DEPTH) - count_i;

  AST_AE_COMB: assert property (@(posedge clk_i) disable iff (mrst_i)
    ae_async_q |-> (ae_o == (count_i <= CW'(ae_off_q)))); // R7
  AST_AE_REG: assert property (@(posedge clk_i) disable iff (mrst_i)
    !ae_async_q |=> (ae_o == ($past(count_i) <= CW'($past(ae_off_q))))); // R9
  AST_AF_COMB: assert property (@(posedge clk_i) disable iff (mrst_i)
    af_async_q |-> (af_o == (free_c <= CW'(af_off_q)))); // R8
  AST_AF_REG: assert property (@(posedge clk_i) disable iff (mrst_i)
    !af_async_q |=> (af_o == ($past(free_c) <= CW'($past(af_off_q))))); // R9
  AST_PRST_KEEP: assert property (@(posedge clk_i) disable iff (mrst_i)
    prst_i |=> ($stable(ae_off_q) && $stable(af_off_q))); // R10
endmodule

bind flag_offset_loader flo_chk #(.DEPTH(DEPTH), .OW(OW), .CW(CW)) u_chk (
  .clk_i(clk_i), .mrst_i(mrst_i), .prst_i(prst_i), .count_i(count_i),
  .ae_off_q(ae_off_q), .af_off_q(af_off_q),
  .ae_async_q(ae_async_q), .af_async_q(af_async_q),
  .ae_o(ae_o), .af_o(af_o)
);

// File: tb/flag_offset_loader_tb.sv
`timescale 1ns/1ps
module flag_offset_loader_tb;
  localparam int DEPTH = 1024;
  localparam int OW = 10;
  localparam int CW = 11;
  localparam int NV = 8;
  // each entry: {count, expected ae, expected af} with ae offset 100, af offset 50
  localparam logic [CW+1:0] VEC [NV] = '{
    {11'd0,    1'b1, 1'b0}, {11'd100, 1'b1, 1'b0}, {11'd101, 1'b0, 1'b0},
    {11'd500,  1'b0, 1'b0}, {11'd973, 1'b0, 1'b0}, {11'd974, 1'b0, 1'b1},
    {11'd1024, 1'b0, 1'b1}, {11'd99,  1'b1, 1'b0}
  };

  logic clk = 0, mrst = 1, prst = 0, ld = 0, wide = 1, ip = 0;
  logic aea = 1, afa = 0, sclk = 0, sen = 0, sdi = 0;
  logic [1:0] fsel = 0;
  logic [17:0] d = 0;
  logic [CW-1:0] count = 0;
  logic ae, af;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flag_offset_loader #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .mrst_i(mrst), .prst_i(prst), .fsel_i(fsel), .ld_i(ld),
    .wide_i(wide), .ip_i(ip), .ae_async_i(aea), .af_async_i(afa), .d_i(d),
    .sclk_i(sclk), .sen_i(sen), .sdi_i(sdi), .count_i(count),
    .ae_o(ae), .af_o(af)
  );

  task automatic chk1(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic flags(input int v, input logic eae, input logic eaf, input string tag);
    @(negedge clk) count = CW'(v);
    @(negedge clk);
    chk1(ae, eae, $sformatf("%s ae count=%0d", tag, v));
    chk1(af, eaf, $sformatf("%s af count=%0d", tag, v));
  endtask

  task automatic mreset(input logic [1:0] fs, input logic l, input logic w,
                        input logic p, input logic a1, input logic a2);
    @(negedge clk);
    fsel = fs; ld = l; wide = w; ip = p; aea = a1; afa = a2; mrst = 1;
    repeat (2) @(negedge clk);
    mrst = 0; ld = 0;
    @(negedge clk);
  endtask

  task automatic pload(input logic [17:0] w);
    @(negedge clk) d = w; ld = 1;
    @(negedge clk) ld = 0;
  endtask

  task automatic sbit(input logic b);
    sdi = b; sen = 1;
    repeat (3) @(negedge clk);
    sclk = 1;
    repeat (3) @(negedge clk);
    sclk = 0;
  endtask

  task automatic sload(input logic [OW-1:0] e, input logic [OW-1:0] f);
    logic [2*OW-1:0] w;
    w = {f, e};
    for (int i = 0; i < 2*OW; i++) sbit(w[i]);
    sen = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state: index {0,2} -> 31
    mreset(2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    flags(31, 1, 0, "R1 preset2");
    flags(32, 0, 0, "R1 preset2");
    flags(993, 0, 1, "R1 preset2");
    flags(992, 0, 0, "R1 preset2");

    // R2 parallel: empty first then full; vector walk for R7/R8
    pload(18'd100);
    pload(18'd50);
    for (int i = 0; i < NV; i++)
      flags(int'(VEC[i][CW+1:2]), VEC[i][1], VEC[i][0], "R2 R7 R8 vector");

    // R9 combinational ae vs registered af
    flags(0, 1, 0, "R9 setup");
    @(negedge clk) count = 11'd1000;
    #1;
    chk1(ae, 1'b0, "R9 comb ae same cycle");
    chk1(af, 1'b0, "R9 reg af holds old");
    @(negedge clk);
    chk1(af, 1'b1, "R9 reg af next cycle");

    // R3 no parity: bits 17:16 ignored
    pload(18'h30000 | 18'd200);
    pload(18'h30000 | 18'd600);
    flags(200, 1, 0, "R3");
    flags(201, 0, 0, "R3");
    flags(424, 0, 1, "R3");
    flags(423, 0, 0, "R3");

    // R1 index 7 -> 1023, ae registered, af combinational
    mreset(2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    flags(1023, 1, 1, "R1 preset7");
    flags(1024, 0, 1, "R1 preset7");
    flags(0, 1, 0, "R1 preset7");
    @(negedge clk) count = 11'd1024;
    #1;
    chk1(af, 1'b1, "R9 comb af same cycle");
    chk1(ae, 1'b1, "R9 reg ae holds old");

    // R4 parity skip: bit 8 set as parity
    pload(18'h0032C);
    pload(18'h00105);
    flags(300, 1, 0, "R4");
    flags(301, 0, 0, "R4");
    flags(1019, 0, 1, "R4");
    flags(1018, 0, 0, "R4");

    // R1 index 0 -> 7; R5 narrow bus with parity set
    mreset(2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    flags(7, 1, 0, "R1 preset0");
    flags(8, 0, 0, "R1 preset0");
    pload(18'h3FFFF);
    pload(18'h00403);
    flags(511, 1, 0, "R5");
    flags(512, 0, 0, "R5");
    flags(1021, 0, 1, "R5");
    flags(1020, 0, 0, "R5");

    // R6 serial LSB first
    sload(10'd77, 10'd9);
    flags(77, 1, 0, "R6");
    flags(78, 0, 0, "R6");
    flags(1015, 0, 1, "R6");
    flags(1014, 0, 0, "R6");

    // R10 partial reset
    pload(18'd40);
    pload(18'd20);
    pload(18'd60);
    @(negedge clk) prst = 1;
    @(negedge clk) prst = 0;
    flags(60, 1, 0, "R10 kept");
    flags(61, 0, 0, "R10 kept");
    flags(1004, 0, 1, "R10 kept");
    flags(1003, 0, 0, "R10 kept");
    pload(18'd70);
    flags(70, 1, 0, "R10 restart par");
    flags(71, 0, 0, "R10 restart par");
    flags(1004, 0, 1, "R10 restart par");
    for (int i = 0; i < 7; i++) sbit(1'b1);
    sen = 0;
    @(negedge clk) prst = 1;
    @(negedge clk) prst = 0;
    sload(10'd5, 10'd2);
    flags(5, 1, 0, "R10 restart ser");
    flags(6, 0, 0, "R10 restart ser");
    flags(1022, 0, 1, "R10 restart ser");
    flags(1021, 0, 0, "R10 restart ser");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule